// File: doc/BRIEF.md
# DMA Channel Termination Controller

This block holds the run, halt and error state of one DMA channel and decides how the channel stops. The transfer engine reports its current phase on a three-bit code. It also reports whether a bus transaction is still open and when a descriptor writeback has finished. An address-decode monitor signals error responses, and software issues start, orderly-stop, abort and status-clear strobes.

There are three termination paths. A descriptor fetch that hits an unmapped address stops the channel at once and writes nothing back. A data-buffer access that hits an unmapped address clears run and requests a writeback with the terminated flag. The halt and error bits follow only once that writeback completes. A software abort asks the engine to stop after the open bus transaction. It then writes the descriptor back with the terminated flag, unless the channel was between descriptors (following a link or chaining), in which case it halts with no writeback. The orderly stop simply clears run and relies on the peripheral to finish.

Top module: `dma_stop_ctrl`

## Requirements
- R1: After reset, run, halt, err, term_flag, stop_req and wb_req are 0 and dev_valid is 1.
- R2: A run_set strobe with halt clear sets run on the next edge; while halt is set, run_set is ignored.
- R3: While running, fetch_err with phase code 1 (descriptor fetch) sets halt and err and clears run on the next edge, with no writeback request.
- R4: While running, data_err with phase code 2 (data transfer) clears run on the next edge and raises wb_req, term_flag and stop_req with dev_valid 1, while halt and err stay 0. An error flag in any other phase has no effect.
- R5: After a data-error writeback request, halt and err are set, and wb_req and term_flag drop, on the edge after wb_done is sampled high.
- R6: An abort while running with phase code 0 to 3 raises stop_req on the next edge. It waits while bus_busy is high. On the edge after bus_busy is sampled low it raises wb_req and term_flag with dev_valid 0. On wb_done it clears run and sets halt, leaving err 0.
- R7: An abort while running with phase code 4 (link) or 5 (chaining) waits for bus_busy low in the same way. It then clears run and sets halt without ever raising wb_req or term_flag.
- R8: run_clr while running clears run on the next edge and leaves halt, err and term_flag at 0.
- R9: While the channel is idle (run clear), abort, fetch_err and data_err have no effect on any output.
- R10: halt_clr clears halt and err_clr clears err, each independently; a set of the same bit in the same cycle wins over its clear.
- R11: In one cycle, a matching error outranks abort, and abort outranks run_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_set | input | 1 | Software strobe: start the channel |
| run_clr | input | 1 | Software strobe: orderly stop |
| abort | input | 1 | Software strobe: forced abort (self-clearing) |
| halt_clr | input | 1 | Write-one clear of halt |
| err_clr | input | 1 | Write-one clear of err |
| phase | input | 3 | Engine phase: 0 none, 1 fetch, 2 transfer, 3 writeback, 4 link, 5 chaining |
| bus_busy | input | 1 | A bus transaction is open |
| fetch_err | input | 1 | Decode error on descriptor fetch |
| data_err | input | 1 | Decode error on data buffer access |
| wb_done | input | 1 | Descriptor writeback completed |
| run | output | 1 | Run bit |
| halt | output | 1 | Halt status bit |
| err | output | 1 | Error status bit |
| term_flag | output | 1 | Terminated flag merged into the writeback |
| stop_req | output | 1 | Engine must stop after the current transaction |
| wb_req | output | 1 | Request a terminating descriptor writeback |
| dev_valid | output | 1 | Device status/command fields in the writeback are meaningful |

## Verification
A wrong internal state shows up within one edge of the triggering strobe. Typical symptoms are run staying high after a fetch error, halt rising before wb_done, or a writeback requested for an abort between descriptors. Losing track of an abort in progress shows as wb_req rising while bus_busy is still high, or as stop_req never dropping. A halt bit cleared by mistake shows as a later run_set being accepted when it should not be.

// File: rtl/dma_stop_ctrl.sv
module dma_stop_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_set,
  input  logic       run_clr,
  input  logic       abort,
  input  logic       halt_clr,
  input  logic       err_clr,
  input  logic [2:0] phase,
  input  logic       bus_busy,
  input  logic       fetch_err,
  input  logic       data_err,
  input  logic       wb_done,
  output logic       run,
  output logic       halt,
  output logic       err,
  output logic       term_flag,
  output logic       stop_req,
  output logic       wb_req,
  output logic       dev_valid
);
  localparam logic [2:0] PH_FETCH = 3'd1;
  localparam logic [2:0] PH_XFER  = 3'd2;
  localparam logic [2:0] PH_LINK  = 3'd4;
  localparam logic [2:0] PH_CHAIN = 3'd5;

  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_RUN   = 2'd1;
  localparam logic [1:0] S_DRAIN = 2'd2;
  localparam logic [1:0] S_WBT   = 2'd3;

  logic [1:0] st;
  logic       run_q, halt_q, err_q, nodesc_q, errwb_q;

  wire between_desc = (phase == PH_LINK) || (phase == PH_CHAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      run_q    <= 1'b0;
      halt_q   <= 1'b0;
      err_q    <= 1'b0;
      nodesc_q <= 1'b0;
      errwb_q  <= 1'b0;
    end else begin
      if (halt_clr) halt_q <= 1'b0;
      if (err_clr)  err_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (run_set && !halt_q) begin
            run_q <= 1'b1;
            st    <= S_RUN;
          end
        end
        S_RUN: begin
          if (fetch_err && phase == PH_FETCH) begin
            run_q  <= 1'b0;
            halt_q <= 1'b1;
            err_q  <= 1'b1;
            st     <= S_IDLE;
          end else if (data_err && phase == PH_XFER) begin
            run_q   <= 1'b0;
            errwb_q <= 1'b1;
            st      <= S_WBT;
          end else if (abort) begin
            nodesc_q <= between_desc;
            errwb_q  <= 1'b0;
            st       <= S_DRAIN;
          end else if (run_clr) begin
            run_q <= 1'b0;
            st    <= S_IDLE;
          end
        end
        S_DRAIN: begin
          if (!bus_busy) begin
            if (nodesc_q) begin
              run_q  <= 1'b0;
              halt_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= S_WBT;
            end
          end
        end
        default: begin
          if (wb_done) begin
            run_q  <= 1'b0;
            halt_q <= 1'b1;
            if (errwb_q) err_q <= 1'b1;
            errwb_q <= 1'b0;
            st      <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign run       = run_q;
  assign halt      = halt_q;
  assign err       = err_q;
  assign wb_req    = (st == S_WBT);
  assign term_flag = (st == S_WBT);
  assign stop_req  = (st == S_DRAIN) || (st == S_WBT);
  assign dev_valid = !((st == S_WBT) && !errwb_q);

  a_r2_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(run_set) && !$past(halt)));

  a_r3_fetch_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && fetch_err && phase == PH_FETCH) |=> (halt && err && !run && !wb_req));

  a_r4_no_run_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !run || !dev_valid);

  a_r5_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(wb_done) || $past(fetch_err)));

  a_r6_wb_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wb_req) && !dev_valid) |-> !$past(bus_busy));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !run_set) |=> (!$rose(halt) && !$rose(err) && !wb_req));

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !halt_clr) |=> halt);
endmodule

// File: tb/test_dma_stop_ctrl.sv
module test_dma_stop_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_set = 0, run_clr = 0, abort = 0, halt_clr = 0, err_clr = 0;
  logic [2:0] phase = 3'd0;
  logic bus_busy = 0, fetch_err = 0, data_err = 0, wb_done = 0;
  logic run, halt, err, term_flag, stop_req, wb_req, dev_valid;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_stop_ctrl i_dma_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .run_set(run_set), .run_clr(run_clr), .abort(abort),
    .halt_clr(halt_clr), .err_clr(err_clr), .phase(phase), .bus_busy(bus_busy),
    .fetch_err(fetch_err), .data_err(data_err), .wb_done(wb_done),
    .run(run), .halt(halt), .err(err), .term_flag(term_flag),
    .stop_req(stop_req), .wb_req(wb_req), .dev_valid(dev_valid));

  // vector order: run halt err term stop wb dev_valid
  function automatic logic [6:0] mk(bit r, bit h, bit e, bit t, bit s, bit w, bit d);
    return {r, h, e, t, s, w, d};
  endfunction

  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] act = {run, halt, err, term_flag, stop_req, wb_req, dev_valid};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    run_set = 0; run_clr = 0; abort = 0; halt_clr = 0; err_clr = 0;
    fetch_err = 0; data_err = 0; wb_done = 0;
  endtask

  task automatic clean();
    halt_clr = 1; err_clr = 1; step();
  endtask

  task automatic start();
    clean();
    run_set = 1; step();
    chk("R2 start", mk(1,0,0,0,0,0,1));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run not finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", mk(0,0,0,0,0,0,1));
    rst_n = 1;
    step();
    chk("R1 after release", mk(0,0,0,0,0,0,1));

    // R9: idle sweep of every phase and event
    for (int p = 0; p < 6; p++)
      for (int ev = 0; ev < 3; ev++) begin
        phase = p[2:0];
        fetch_err = (ev == 0); data_err = (ev == 1); abort = (ev == 2);
        step();
        chk("R9 idle event", mk(0,0,0,0,0,0,1));
      end

    // sweep of running channel: phase x event x bus busy length
    for (int p = 0; p < 6; p++)
      for (int ev = 0; ev < 3; ev++)
        for (int nb = 0; nb < 3; nb++) begin
          start();
          phase = p[2:0];
          if (ev == 0) begin
            fetch_err = 1; step();
            if (p == 1) chk("R3 fetch error", mk(0,1,1,0,0,0,1));
            else begin
              chk("R4 error ignored off-phase", mk(1,0,0,0,0,0,1));
              run_clr = 1; step();
              chk("R8 orderly stop", mk(0,0,0,0,0,0,1));
            end
          end else if (ev == 1) begin
            data_err = 1; step();
            if (p == 2) begin
              chk("R4 data error", mk(0,0,0,1,1,1,1));
              for (int k = 0; k < nb; k++) begin
                step();
                chk("R5 wait writeback", mk(0,0,0,1,1,1,1));
              end
              wb_done = 1; step();
              chk("R5 status after writeback", mk(0,1,1,0,0,0,1));
            end else begin
              chk("R4 error ignored off-phase", mk(1,0,0,0,0,0,1));
              run_clr = 1; step();
              chk("R8 orderly stop", mk(0,0,0,0,0,0,1));
            end
          end else begin
            abort = 1; bus_busy = (nb > 0); step();
            chk("R6 abort stop request", mk(1,0,0,0,1,0,1));
            for (int k = 0; k < nb; k++) begin
              bus_busy = 1; step();
              chk("R6 drain while busy", mk(1,0,0,0,1,0,1));
            end
            bus_busy = 0; step();
            if (p >= 4) chk("R7 abort between descriptors", mk(0,1,0,0,0,0,1));
            else begin
              chk("R6 abort writeback", mk(1,0,0,1,1,1,0));
              wb_done = 1; step();
              chk("R6 abort done", mk(0,1,0,0,0,0,1));
            end
          end
          phase = 0;
        end

    // R2: run_set ignored while halt set
    start();
    phase = 1; fetch_err = 1; step();
    run_set = 1; step();
    chk("R2 start ignored under halt", mk(0,1,1,0,0,0,1));

    // R10: independent clears
    halt_clr = 1; step();
    chk("R10 halt cleared alone", mk(0,0,1,0,0,0,1));
    err_clr = 1; step();
    chk("R10 err cleared", mk(0,0,0,0,0,0,1));

    // R10: set wins over clear in same cycle
    start();
    phase = 1; fetch_err = 1; halt_clr = 1; err_clr = 1; step();
    chk("R10 set beats clear", mk(0,1,1,0,0,0,1));

    // R11: error beats abort
    start();
    phase = 2; data_err = 1; abort = 1; step();
    chk("R11 error beats abort", mk(0,0,0,1,1,1,1));
    wb_done = 1; step();
    chk("R11 error path completes", mk(0,1,1,0,0,0,1));

    // R11: abort beats run_clr
    start();
    phase = 4; abort = 1; run_clr = 1; step();
    chk("R11 abort beats run_clr", mk(1,0,0,0,1,0,1));
    step();
    chk("R11 abort completes", mk(0,1,0,0,0,0,1));

    // R8: second abort/run_clr during drain has no effect
    start();
    phase = 2; abort = 1; bus_busy = 1; step();
    abort = 1; run_clr = 1; bus_busy = 1; step();
    chk("R8 strobes ignored in drain", mk(1,0,0,0,1,0,1));
    bus_busy = 0; step();
    chk("R6 writeback after drain", mk(1,0,0,1,1,1,0));
    wb_done = 1; step();
    chk("R6 final", mk(0,1,0,0,0,0,1));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule